// File: doc/BRIEF.md
# Data Access Permission Checker

This block sits after the translation lookup in a load/store pipeline and decides the fate of one data access per cycle. It checks the virtual address against the access size for natural alignment. It recognises a kernel-only, direct-mapped superpage window. Otherwise it applies the per-privilege-mode read and write enables and the fault-on-read and fault-on-write markers that came back with the matching translation entry.

The outcome is registered. One cycle after a request it presents three things: a physical address, a fault class and a four-bit status word. A pipeline uses the fault class to pick the trap to take, and the status word tells the trap handler why. The translation array is not part of this block. It only consumes the hit flag, the page frame number and the permission fields of the entry that matched.

Top module: `dchk_top`

## Requirements
- R1: While `rst` is high, and on the clock edge after it, `rsp_valid`, `rsp_fault`, `rsp_status` and `rsp_paddr` are all zero. Every request with `req_valid` high gets its response exactly one clock later. A cycle without a request gives `rsp_valid` low one clock later.
- R2: `size_log2` gives the access size as 2^`size_log2` bytes (0 = 1 byte, 3 = 8 bytes). An access is misaligned when `vaddr` AND (size − 1) is nonzero. It then gets fault ALIGN (code 1), with status bit 0 (WR) set only for writes.
- R3: The checks are ranked alignment first, then superpage, then translation miss, then permissions. Only the highest-ranked failing check reports.
- R4: An access is a superpage access when `vaddr[47:41]` equals 0x7E. Such an access in any mode other than kernel (mode 0) gets fault ACV (code 2), with status bit 1 (ACV) set and WR set for writes.
- R5: A kernel superpage access passes with fault NONE (code 0) and status 0. Its physical address is `vaddr[43:0]`, with bits 43:40 forced to one when bit 40 is set. The translation inputs have no effect on this case.
- R6: An aligned non-superpage access with `tlb_hit` low gets fault MISS (code 4), with WR set for writes.
- R7: The privilege mode (0 kernel, 1 executive, 2 supervisor, 3 user) selects bit `mode` of `tlb_rd_en` for reads and of `tlb_wr_en` for writes.
- R8: A write whose selected write enable is clear gets fault PAGE (code 3), with status WR and ACV set and bit 3 (FONW) copied from `tlb_fault_wr`.
- R9: A permitted write with `tlb_fault_wr` set gets fault PAGE, with status WR and FONW.
- R10: A read whose selected read enable is clear gets fault ACV, with status ACV set and bit 2 (FONR) copied from `tlb_fault_rd`.
- R11: A permitted read with `tlb_fault_rd` set gets fault PAGE, with status FONR only.
- R12: A permitted translated access with no fault-on bit for its direction gets fault NONE and status 0, and its physical address is `{tlb_ppn, vaddr[12:0]}`. Every faulting response carries physical address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| vaddr | input | 64 | Virtual address |
| size_log2 | input | 2 | Log2 of access size in bytes |
| is_write | input | 1 | 1 = store, 0 = load |
| priv_mode | input | 2 | 0 kernel, 1 executive, 2 supervisor, 3 user |
| tlb_hit | input | 1 | Translation entry matched |
| tlb_ppn | input | 31 | Page frame number of the matching entry |
| tlb_rd_en | input | 4 | Read enable per mode |
| tlb_wr_en | input | 4 | Write enable per mode |
| tlb_fault_rd | input | 1 | Entry traps on read |
| tlb_fault_wr | input | 1 | Entry traps on write |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 3 | 0 NONE, 1 ALIGN, 2 ACV, 3 PAGE, 4 MISS |
| rsp_status | output | 4 | bit0 WR, bit1 ACV, bit2 FONR, bit3 FONW |
| rsp_paddr | output | 44 | Physical address |

## Verification
The bench builds the block with its default parameters: 64-bit virtual and 44-bit physical addresses, 8 KiB pages and four modes. With these values the 7-bit space field at bits 47:41 and the bit-40 extension into bits 43:40 can both be reached by stimulus. Directed cases walk every mode against every enable and fault-on combination in both directions, and stack failing conditions to test the ranking. A random phase biases addresses toward the superpage window and toward aligned offsets so that all paths get steady traffic.

// File: rtl/dchk_pkg.sv
package dchk_pkg;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_ALIGN = 3'd1,
        FLT_ACV   = 3'd2,
        FLT_PAGE  = 3'd3,
        FLT_MISS  = 3'd4
    } fault_e;

    localparam int ST_WR   = 0;
    localparam int ST_ACV  = 1;
    localparam int ST_FONR = 2;
    localparam int ST_FONW = 3;
    localparam int ST_W    = 4;

    localparam logic [1:0] MODE_KERNEL = 2'd0;

    typedef struct packed {
        fault_e            fault;
        logic [ST_W-1:0]   status;
    } verdict_t;

    function automatic logic [ST_W-1:0] pack_status(
        input logic wr, input logic acv, input logic fonr, input logic fonw);
        logic [ST_W-1:0] s;
        s = '0;
        s[ST_WR]   = wr;
        s[ST_ACV]  = acv;
        s[ST_FONR] = fonr;
        s[ST_FONW] = fonw;
        return s;
    endfunction

endpackage

// File: rtl/dchk_align.sv
module dchk_align #(
    parameter int VA_W      = 64,
    parameter int MAX_SZ_LG = 3
) (
    input  logic [VA_W-1:0] vaddr,
    input  logic [1:0]      size_log2,
    output logic            misaligned
);
    localparam int LOW_W = 1 << MAX_SZ_LG;

    logic [LOW_W-1:0] low_mask;

    always_comb begin
        low_mask   = (LOW_W'(1) << size_log2) - LOW_W'(1);
        misaligned = |(vaddr[LOW_W-1:0] & low_mask);
    end
endmodule

// File: rtl/dchk_superpage.sv
module dchk_superpage #(
    parameter int          VA_W     = 64,
    parameter int          PA_W     = 44,
    parameter int          SPACE_HI = 47,
    parameter int          SPACE_LO = 41,
    parameter logic [6:0]  SP_TAG   = 7'h7E,
    parameter int          EXT_BIT  = 40
) (
    input  logic [VA_W-1:0] vaddr,
    output logic            in_window,
    output logic [PA_W-1:0] direct_pa
);
    localparam int SPACE_W = SPACE_HI - SPACE_LO + 1;

    assign in_window = (vaddr[SPACE_HI:SPACE_LO] == SP_TAG[SPACE_W-1:0]);

    for (genvar i = 0; i < PA_W; i++) begin : g_pa
        if (i > EXT_BIT) begin : g_ext
            assign direct_pa[i] = vaddr[i] | vaddr[EXT_BIT];
        end else begin : g_pass
            assign direct_pa[i] = vaddr[i];
        end
    end
endmodule

// File: rtl/dchk_perm.sv
module dchk_perm
    import dchk_pkg::*;
#(
    parameter int N_MODES = 4,
    parameter int MODE_W  = 2
) (
    input  logic [MODE_W-1:0]  mode,
    input  logic               is_write,
    input  logic [N_MODES-1:0] rd_en,
    input  logic [N_MODES-1:0] wr_en,
    input  logic               fault_rd,
    input  logic               fault_wr,
    output verdict_t           verdict
);
    logic rd_ok;
    logic wr_ok;

    always_comb begin
        rd_ok = rd_en[mode];
        wr_ok = wr_en[mode];
        verdict.fault  = FLT_NONE;
        verdict.status = '0;
        if (is_write) begin
            if (!wr_ok) begin
                verdict.fault  = FLT_PAGE;
                verdict.status = pack_status(1'b1, 1'b1, 1'b0, fault_wr);
            end else if (fault_wr) begin
                verdict.fault  = FLT_PAGE;
                verdict.status = pack_status(1'b1, 1'b0, 1'b0, 1'b1);
            end
        end else begin
            if (!rd_ok) begin
                verdict.fault  = FLT_ACV;
                verdict.status = pack_status(1'b0, 1'b1, fault_rd, 1'b0);
            end else if (fault_rd) begin
                verdict.fault  = FLT_PAGE;
                verdict.status = pack_status(1'b0, 1'b0, 1'b1, 1'b0);
            end
        end
    end
endmodule

// File: rtl/dchk_top.sv
module dchk_top
    import dchk_pkg::*;
#(
    parameter int VA_W    = 64,
    parameter int PA_W    = 44,
    parameter int PG_BITS = 13,
    parameter int N_MODES = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [VA_W-1:0]         vaddr,
    input  logic [1:0]              size_log2,
    input  logic                    is_write,
    input  logic [1:0]              priv_mode,
    input  logic                    tlb_hit,
    input  logic [PA_W-PG_BITS-1:0] tlb_ppn,
    input  logic [N_MODES-1:0]      tlb_rd_en,
    input  logic [N_MODES-1:0]      tlb_wr_en,
    input  logic                    tlb_fault_rd,
    input  logic                    tlb_fault_wr,
    output logic                    rsp_valid,
    output logic [2:0]              rsp_fault,
    output logic [ST_W-1:0]         rsp_status,
    output logic [PA_W-1:0]         rsp_paddr
);
    localparam int MODE_W = $clog2(N_MODES);

    logic            misaligned;
    logic            sp_hit;
    logic [PA_W-1:0] sp_pa;
    verdict_t        perm_v;
    verdict_t        next_v;
    logic [PA_W-1:0] next_pa;

    dchk_align #(.VA_W(VA_W)) u_align (
        .vaddr      (vaddr),
        .size_log2  (size_log2),
        .misaligned (misaligned)
    );

    dchk_superpage #(.VA_W(VA_W), .PA_W(PA_W)) u_sp (
        .vaddr     (vaddr),
        .in_window (sp_hit),
        .direct_pa (sp_pa)
    );

    dchk_perm #(.N_MODES(N_MODES), .MODE_W(MODE_W)) u_perm (
        .mode     (priv_mode[MODE_W-1:0]),
        .is_write (is_write),
        .rd_en    (tlb_rd_en),
        .wr_en    (tlb_wr_en),
        .fault_rd (tlb_fault_rd),
        .fault_wr (tlb_fault_wr),
        .verdict  (perm_v)
    );

    always_comb begin
        next_v.fault  = FLT_NONE;
        next_v.status = '0;
        next_pa       = '0;
        if (misaligned) begin
            next_v.fault  = FLT_ALIGN;
            next_v.status = pack_status(is_write, 1'b0, 1'b0, 1'b0);
        end else if (sp_hit) begin
            if (priv_mode != MODE_KERNEL) begin
                next_v.fault  = FLT_ACV;
                next_v.status = pack_status(is_write, 1'b1, 1'b0, 1'b0);
            end else begin
                next_pa = sp_pa;
            end
        end else if (!tlb_hit) begin
            next_v.fault  = FLT_MISS;
            next_v.status = pack_status(is_write, 1'b0, 1'b0, 1'b0);
        end else begin
            next_v = perm_v;
            if (perm_v.fault == FLT_NONE) begin
                next_pa = {tlb_ppn, vaddr[PG_BITS-1:0]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !req_valid) begin
            rsp_valid  <= 1'b0;
            rsp_fault  <= 3'd0;
            rsp_status <= '0;
            rsp_paddr  <= '0;
        end else begin
            rsp_valid  <= 1'b1;
            rsp_fault  <= next_v.fault;
            rsp_status <= next_v.status;
            rsp_paddr  <= next_pa;
        end
    end
endmodule

// File: rtl/dchk_sva.sv
module dchk_sva #(
    parameter int VA_W    = 64,
    parameter int PA_W    = 44,
    parameter int PG_BITS = 13,
    parameter int N_MODES = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    req_valid,
    input logic [VA_W-1:0]         vaddr,
    input logic [1:0]              size_log2,
    input logic                    is_write,
    input logic [1:0]              priv_mode,
    input logic                    tlb_hit,
    input logic [N_MODES-1:0]      tlb_wr_en,
    input logic                    rsp_valid,
    input logic [2:0]              rsp_fault,
    input logic [3:0]              rsp_status,
    input logic [PA_W-1:0]         rsp_paddr
);
    logic chk_mis;
    logic chk_sp;
    assign chk_mis = |(vaddr[7:0] & ((8'd1 << size_log2) - 8'd1));
    assign chk_sp  = (vaddr[47:41] == 7'h7E);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!rsp_valid && rsp_status == 4'd0)); // R1

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R1

    AST_ALIGN_FIRST: assert property (@(posedge clk) disable iff (rst)
        (req_valid && chk_mis) |=>
        (rsp_fault == 3'd1 && rsp_status[0] == $past(is_write))); // R2

    AST_SP_USER_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !chk_mis && chk_sp && priv_mode != 2'd0) |=>
        (rsp_fault == 3'd2 && rsp_status[1])); // R4

    AST_MISS_RANK: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !chk_mis && !chk_sp && !tlb_hit) |=> rsp_fault == 3'd4); // R6

    AST_WRITE_DENY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !chk_mis && !chk_sp && tlb_hit && is_write &&
         !tlb_wr_en[priv_mode]) |=>
        (rsp_fault == 3'd3 && rsp_status[0] && rsp_status[1])); // R8

    AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 3'd0) |-> rsp_paddr == '0); // R12
endmodule

bind dchk_top dchk_sva #(
    .VA_W(VA_W), .PA_W(PA_W), .PG_BITS(PG_BITS), .N_MODES(N_MODES)
) u_sva (
    .clk(clk), .rst(rst), .req_valid(req_valid), .vaddr(vaddr),
    .size_log2(size_log2), .is_write(is_write), .priv_mode(priv_mode),
    .tlb_hit(tlb_hit), .tlb_wr_en(tlb_wr_en), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_status(rsp_status), .rsp_paddr(rsp_paddr)
);

// File: tb/sim_dchk_top.sv
`timescale 1ns/1ps
module sim_dchk_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [63:0] vaddr;
    logic [1:0]  size_log2;
    logic        is_write;
    logic [1:0]  priv_mode;
    logic        tlb_hit;
    logic [30:0] tlb_ppn;
    logic [3:0]  tlb_rd_en;
    logic [3:0]  tlb_wr_en;
    logic        tlb_fault_rd;
    logic        tlb_fault_wr;
    logic        rsp_valid;
    logic [2:0]  rsp_fault;
    logic [3:0]  rsp_status;
    logic [43:0] rsp_paddr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    dchk_top u0 (.*);

    // expected response
    int          e_fault;
    int          e_status;
    logic [63:0] e_pa;
    string       e_req;

    function automatic void model();
        longint unsigned bytes;
        longint unsigned pa;
        bit wr_ok, rd_ok;
        bytes    = 64'd1 << size_log2;
        e_fault  = 0;
        e_status = 0;
        e_pa     = 0;
        if ((vaddr % bytes) != 0) begin
            e_req = "R2";
            e_fault = 1;
            e_status = is_write ? 1 : 0;
        end else if (((vaddr >> 41) & 64'h7F) == 64'h7E) begin
            if (priv_mode != 0) begin
                e_req = "R4";
                e_fault = 2;
                e_status = 2 + (is_write ? 1 : 0);
            end else begin
                e_req = "R5";
                pa = vaddr & ((64'd1 << 44) - 1);
                if (((pa >> 40) & 1) == 1) pa = pa | 64'hF0000000000;
                e_pa = pa;
            end
        end else if (!tlb_hit) begin
            e_req = "R6";
            e_fault = 4;
            e_status = is_write ? 1 : 0;
        end else begin
            wr_ok = tlb_wr_en[priv_mode];
            rd_ok = tlb_rd_en[priv_mode];
            if (is_write && !wr_ok) begin
                e_req = "R8"; e_fault = 3; e_status = 3 + (tlb_fault_wr ? 8 : 0);
            end else if (is_write && tlb_fault_wr) begin
                e_req = "R9"; e_fault = 3; e_status = 9;
            end else if (!is_write && !rd_ok) begin
                e_req = "R10"; e_fault = 2; e_status = 2 + (tlb_fault_rd ? 4 : 0);
            end else if (!is_write && tlb_fault_rd) begin
                e_req = "R11"; e_fault = 3; e_status = 4;
            end else begin
                e_req = "R12";
                e_pa = (64'(tlb_ppn) * 64'd8192) + (vaddr % 64'd8192);
            end
        end
    endfunction

    task automatic compare(input bit expv, input string tag);
        checks++;
        if (rsp_valid !== expv ||
            (expv && (int'(rsp_fault) != e_fault || int'(rsp_status) != e_status ||
                      64'(rsp_paddr) != e_pa))) begin
            fails++;
            $display("FAIL %s: got v=%0b f=%0d s=%h pa=%h, want v=%0b f=%0d s=%h pa=%h",
                     tag, rsp_valid, rsp_fault, rsp_status, rsp_paddr,
                     expv, e_fault, e_status, e_pa[43:0]);
        end
    endtask

    task automatic access(input logic [63:0] va, input int sz, input bit wr,
                          input int md, input bit hit, input logic [30:0] ppn,
                          input logic [3:0] re, input logic [3:0] we,
                          input bit fr, input bit fw);
        req_valid = 1; vaddr = va; size_log2 = 2'(sz); is_write = wr;
        priv_mode = 2'(md); tlb_hit = hit; tlb_ppn = ppn;
        tlb_rd_en = re; tlb_wr_en = we; tlb_fault_rd = fr; tlb_fault_wr = fw;
        model();
        @(posedge clk); #1;
        compare(1'b1, e_req);
        req_valid = 0;
    endtask

    task automatic idle();
        req_valid = 0;
        vaddr = 64'h7; size_log2 = 2'd3;
        @(posedge clk); #1;
        compare(1'b0, "R1");
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        if (!done) begin
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] sp_base;
        sp_base = 64'h7E << 41;
        rst = 1; req_valid = 1; vaddr = 0; size_log2 = 0; is_write = 0;
        priv_mode = 0; tlb_hit = 1; tlb_ppn = 0; tlb_rd_en = 4'hF;
        tlb_wr_en = 4'hF; tlb_fault_rd = 0; tlb_fault_wr = 0;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (rsp_valid !== 0 || rsp_fault !== 0 || rsp_status !== 0 || rsp_paddr !== 0) begin
            fails++;
            $display("FAIL R1: reset outputs v=%0b f=%0d s=%h pa=%h, expected all zero",
                     rsp_valid, rsp_fault, rsp_status, rsp_paddr);
        end
        rst = 0; req_valid = 0;
        idle();

        // R2 alignment per size, both directions
        for (int s = 0; s < 4; s++) begin
            access(64'h1000 + 64'(1 << s) / 2 + 64'd1 * (s == 0 ? 0 : 0), s, 1, 0, 1,
                   31'h55, 4'hF, 4'hF, 0, 0);
            access(64'h2001, s, 0, 3, 1, 31'h55, 4'hF, 4'hF, 0, 0);
        end
        // R3 ranking: misaligned superpage user miss -> align
        access(sp_base | 64'h3, 2, 1, 3, 0, 31'h1, 4'h0, 4'h0, 1, 1);
        // R3: superpage user with miss -> ACV, not miss
        access(sp_base | 64'h8, 3, 0, 2, 0, 31'h1, 4'h0, 4'h0, 1, 1);
        // R4 every non-kernel mode, both directions
        for (int m = 1; m < 4; m++) begin
            access(sp_base | 64'h40, 3, 0, m, 1, 31'h7, 4'hF, 4'hF, 0, 0);
            access(sp_base | 64'h40, 3, 1, m, 1, 31'h7, 4'hF, 4'hF, 0, 0);
        end
        // R5 kernel superpage, bit 40 clear and set, tlb inputs ignored
        access(sp_base | 64'h0_0123_4560, 2, 0, 0, 0, 31'h7FFF_FFFF, 4'h0, 4'h0, 1, 1);
        access(sp_base | (64'd1 << 40) | 64'hABC0, 3, 1, 0, 0, 31'h0, 4'h0, 4'h0, 1, 1);
        // R6 miss
        access(64'h1234_0000, 3, 0, 1, 0, 31'h9, 4'hF, 4'hF, 0, 0);
        access(64'h1234_0000, 3, 1, 1, 0, 31'h9, 4'hF, 4'hF, 0, 0);
        // R7..R12 exhaustive modes x one-hot enables x fault-on x direction
        for (int m = 0; m < 4; m++)
            for (int e = 0; e < 4; e++)
                for (int f = 0; f < 4; f++)
                    for (int w = 0; w < 2; w++)
                        access(64'h0000_00AB_CDE0_1238, 3, bit'(w), m, 1, 31'h2AAA_5555,
                               4'(1 << e), 4'(1 << ((e + 1) % 4)), f[0], f[1]);
        idle();
        // random phase
        for (int i = 0; i < 600; i++) begin
            logic [63:0] va;
            va = {$urandom, $urandom};
            if ($urandom % 3 == 0) va[47:41] = 7'h7E;
            if ($urandom % 2 == 0) va[2:0] = 3'd0;
            if ($urandom % 8 == 0) idle();
            access(va, int'($urandom % 4), bit'($urandom % 2), int'($urandom % 4),
                   bit'($urandom % 4 != 0), 31'($urandom), 4'($urandom), 4'($urandom),
                   bit'($urandom % 2), bit'($urandom % 2));
        end
        idle();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule